// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block walks a data mover through a rectangular pattern of element addresses. Software loads a start address, a row length (inner count), a row total (outer count), a signed in-row increment (inner step) and a signed row-to-row increment (outer step). A start pulse then copies these settings into working registers and presents the first address. Each element handshake from the mover advances the address and steps the counters.

Inside a row the address moves by the inner step. On the last element of a row it moves by the outer step instead. The outer step may be smaller than the inner step, or negative. With a negative outer step, a stream of interleaved samples can be split into separate planes as it is moved.

When the last row ends, the block either stops and returns to idle (linear mode), or reloads the start address and both counts and carries on (circular mode). The interrupt pulse follows either every row end or every buffer end.

The control machine has two states: `ST_IDLE` and `ST_RUN`. It has three transitions:
- start (`ST_IDLE`→`ST_RUN` on `start`);
- wrap (`ST_RUN`→`ST_RUN` on the final handshake in circular mode);
- finish (`ST_RUN`→`ST_IDLE` on the final handshake in linear mode).

A one-dimensional transfer is the case where the outer count is 1.

Top module: `dma2d_agen`

## Requirements
- R1: After reset `addr_valid`, `row_done`, `buf_done` and `irq` are all 0.
- R2: A configuration write (`cfg_we`) is taken only in `ST_IDLE`. A write made while running has no effect: a later start with no new writes begins at the previously written start address.
- R3: In `ST_IDLE`, `start` moves the block to `ST_RUN`. From the next cycle, `addr_valid` is 1 and `addr_out` equals the start address.
- R4: A handshake (`elem_ack` with `addr_valid`) on an element that is not the last of its row adds the inner step to the address. The inner step is the 16-bit two's complement value in `cfg_wdata[15:0]`, sign-extended.
- R5: A handshake on the last element of a row adds the sign-extended outer step instead, reloads the inner count and decrements the outer count. A negative outer step is allowed.
- R6: A count field (low 16 bits) holding 0 means 65536 elements or rows.
- R7: `row_done` is a one-cycle pulse in the cycle after the handshake on the last element of each row. `buf_done` is a one-cycle pulse after the handshake on the last element of the last row, together with `row_done`.
- R8: In linear mode (mode bit 0 = 0), `addr_valid` is 0 in the cycle after the final handshake.
- R9: In circular mode (mode bit 0 = 1), the block stays in `ST_RUN` after the final handshake, and the next address is the start address with both counts reloaded.
- R10: When mode bit 1 is 1, `irq` pulses together with each `row_done`. Otherwise `irq` pulses together with each `buf_done`.
- R11: With outer count 1 the transfer is one-dimensional: the inner step is applied between every pair of elements, and `buf_done` follows the last one.
- R12: While idle, `elem_ack` has no effect: no pulses are produced and `addr_valid` stays 0.
- R13: Register selects on `cfg_sel`: 0 start address, 1 inner count, 2 outer count, 3 inner step, 4 outer step, 5 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW (32) | Configuration write data |
| start | input | 1 | Begin a transfer (idle only) |
| elem_ack | input | 1 | Data mover consumed the current address |
| addr_out | output | AW (32) | Current element address |
| addr_valid | output | 1 | Block is running, `addr_out` is meaningful |
| row_done | output | 1 | Row completed pulse |
| buf_done | output | 1 | Buffer completed pulse |
| irq | output | 1 | Interrupt pulse, per row or per buffer |

## Verification
On the last element of the last row, three things happen in the same cycle: the row-end action, the buffer-end action and the wrap-or-finish decision.

The bench provokes this corner in every transfer. It uses small shapes, negative outer steps, handshakes with and without gaps, and both interrupt modes. A scoreboard predicts, for each handshake, the address and whether `row_done`, `buf_done`, `irq` and a still-valid address must follow one cycle later.

In circular mode the same cycle must also reload the start address while raising both pulses. The bench judges this by the address popped for the next handshake.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } agen_state_e;

    localparam logic [2:0] SEL_BASE  = 3'd0;
    localparam logic [2:0] SEL_ICNT  = 3'd1;
    localparam logic [2:0] SEL_OCNT  = 3'd2;
    localparam logic [2:0] SEL_ISTEP = 3'd3;
    localparam logic [2:0] SEL_OSTEP = 3'd4;
    localparam logic [2:0] SEL_MODE  = 3'd5;

    localparam int MODE_CIRC_BIT   = 0;
    localparam int MODE_ROWIRQ_BIT = 1;

endpackage

// File: rtl/dma2d_cfg_bank.sv
module dma2d_cfg_bank
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] base_o,
    output logic [CW-1:0] icnt_o,
    output logic [CW-1:0] ocnt_o,
    output logic [CW-1:0] istep_o,
    output logic [CW-1:0] ostep_o,
    output logic          circ_o,
    output logic          rowirq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_o   <= '0;
            icnt_o   <= CW'(1);
            ocnt_o   <= CW'(1);
            istep_o  <= '0;
            ostep_o  <= '0;
            circ_o   <= 1'b0;
            rowirq_o <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_BASE:  base_o  <= wdata;
                SEL_ICNT:  icnt_o  <= wdata[CW-1:0];
                SEL_OCNT:  ocnt_o  <= wdata[CW-1:0];
                SEL_ISTEP: istep_o <= wdata[CW-1:0];
                SEL_OSTEP: ostep_o <= wdata[CW-1:0];
                SEL_MODE: begin
                    circ_o   <= wdata[MODE_CIRC_BIT];
                    rowirq_o <= wdata[MODE_ROWIRQ_BIT];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma2d_span_counter.sv
module dma2d_span_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    input  logic [CW-1:0] load_val,
    output logic          last_o
);

    localparam int NW = CW + 1;
    localparam logic [NW-1:0] FULL_SPAN = NW'(1) << CW;

    logic [NW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= NW'(1);
        end else if (load) begin
            cnt <= (load_val == '0) ? FULL_SPAN : {1'b0, load_val};
        end else if (dec) begin
            cnt <= cnt - NW'(1);
        end
    end

    assign last_o = (cnt == NW'(1));

endmodule

// File: rtl/dma2d_addr_walk.sv
module dma2d_addr_walk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          use_outer,
    input  logic [CW-1:0] istep,
    input  logic [CW-1:0] ostep,
    output logic [AW-1:0] addr_o
);

    localparam int XW = AW - CW;

    logic [CW-1:0] step;
    logic [AW-1:0] step_ext;

    always_comb begin
        step     = use_outer ? ostep : istep;
        step_ext = {{XW{step[CW-1]}}, step};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load) begin
            addr_o <= base;
        end else if (adv) begin
            addr_o <= addr_o + step_ext;
        end
    end

endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          start,
    input  logic          elem_ack,
    output logic [AW-1:0] addr_out,
    output logic          addr_valid,
    output logic          row_done,
    output logic          buf_done,
    output logic          irq
);

    agen_state_e state, state_nx;

    logic [AW-1:0] c_base;
    logic [CW-1:0] c_icnt, c_ocnt, c_istep, c_ostep;
    logic          c_circ, c_rowirq;

    logic [AW-1:0] w_base;
    logic [CW-1:0] w_icnt, w_ocnt, w_istep, w_ostep;
    logic          w_circ, w_rowirq;

    logic go, take, in_last, out_last, row_end, buf_end, wrap, finish;
    logic [CW-1:0] in_load_val, out_load_val;

    dma2d_cfg_bank #(.AW(AW), .CW(CW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && (state == ST_IDLE)),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .base_o   (c_base),
        .icnt_o   (c_icnt),
        .ocnt_o   (c_ocnt),
        .istep_o  (c_istep),
        .ostep_o  (c_ostep),
        .circ_o   (c_circ),
        .rowirq_o (c_rowirq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_base   <= '0;
            w_icnt   <= CW'(1);
            w_ocnt   <= CW'(1);
            w_istep  <= '0;
            w_ostep  <= '0;
            w_circ   <= 1'b0;
            w_rowirq <= 1'b0;
        end else if (go) begin
            w_base   <= c_base;
            w_icnt   <= c_icnt;
            w_ocnt   <= c_ocnt;
            w_istep  <= c_istep;
            w_ostep  <= c_ostep;
            w_circ   <= c_circ;
            w_rowirq <= c_rowirq;
        end
    end

    always_comb begin
        go           = (state == ST_IDLE) && start;
        take         = (state == ST_RUN) && elem_ack;
        row_end      = take && in_last;
        buf_end      = row_end && out_last;
        wrap         = buf_end && w_circ;
        finish       = buf_end && !w_circ;
        in_load_val  = (state == ST_IDLE) ? c_icnt : w_icnt;
        out_load_val = (state == ST_IDLE) ? c_ocnt : w_ocnt;
    end

    dma2d_span_counter #(.CW(CW)) u_inner (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go || row_end),
        .dec      (take),
        .load_val (in_load_val),
        .last_o   (in_last)
    );

    dma2d_span_counter #(.CW(CW)) u_outer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go || wrap),
        .dec      (row_end),
        .load_val (out_load_val),
        .last_o   (out_last)
    );

    dma2d_addr_walk #(.AW(AW), .CW(CW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go || wrap),
        .base      ((state == ST_IDLE) ? c_base : w_base),
        .adv       (take),
        .use_outer (in_last),
        .istep     (w_istep),
        .ostep     (w_ostep),
        .addr_o    (addr_out)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go)     state_nx = ST_RUN;
            ST_RUN:  if (finish) state_nx = ST_IDLE;
            default:             state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_done <= 1'b0;
            buf_done <= 1'b0;
            irq      <= 1'b0;
        end else begin
            row_done <= row_end;
            buf_done <= buf_end;
            irq      <= w_rowirq ? row_end : buf_end;
        end
    end

    assign addr_valid = (state == ST_RUN);

endmodule

// File: rtl/dma2d_agen_chk.sv
module dma2d_agen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          elem_ack,
    input logic [AW-1:0] addr_out,
    input logic          addr_valid,
    input logic          row_done,
    input logic          buf_done,
    input logic          irq
);

    p_row_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> $past(elem_ack && addr_valid));

    p_buf_with_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> row_done);

    p_irq_follows_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> row_done);

    p_rise_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> $past(start));

    p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !elem_ack) |=> $stable(addr_out));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !start) |=> (!addr_valid && !row_done));

    p_fall_after_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_valid) |-> buf_done);

endmodule

bind dma2d_agen dma2d_agen_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .elem_ack   (elem_ack),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .row_done   (row_done),
    .buf_done   (buf_done),
    .irq        (irq)
);

// File: tb/dma2d_agen_test.sv
module dma2d_agen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        elem_ack = 1'b0;
    logic [31:0] addr_out;
    logic        addr_valid, row_done, buf_done, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma2d_agen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .elem_ack(elem_ack),
        .addr_out(addr_out), .addr_valid(addr_valid), .row_done(row_done),
        .buf_done(buf_done), .irq(irq)
    );

    typedef struct {
        logic [31:0] addr;
        bit row_end;
        bit buf_end;
        bit circ;
        bit rowirq;
    } exp_t;

    exp_t q[$];
    exp_t pend;
    bit   pend_valid = 0;

    logic [31:0] m_base = 0;
    logic [15:0] m_icnt = 1, m_ocnt = 1, m_istep = 0, m_ostep = 0;
    bit          m_circ = 0, m_rowirq = 0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int span(logic [15:0] v);
        return (v == 16'd0) ? 65536 : int'(v);
    endfunction

    function automatic logic [31:0] sext(logic [15:0] s);
        return {{16{s[15]}}, s};
    endfunction

    // Monitor: compares observed outputs with the queued predictions
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n) begin
                if (pend_valid) begin
                    check(row_done == pend.row_end, "R7 row_done", 32'(row_done), 32'(pend.row_end));
                    check(buf_done == pend.buf_end, "R7 buf_done", 32'(buf_done), 32'(pend.buf_end));
                    check(irq == (pend.rowirq ? pend.row_end : pend.buf_end), "R10 irq",
                          32'(irq), 32'(pend.rowirq ? pend.row_end : pend.buf_end));
                    if (pend.buf_end && pend.circ)
                        check(addr_valid == 1'b1, "R9 stays running", 32'(addr_valid), 32'd1);
                    if (pend.buf_end && !pend.circ)
                        check(addr_valid == 1'b0, "R8 idle after buffer", 32'(addr_valid), 32'd0);
                end else begin
                    check(!row_done && !buf_done && !irq, "R12 no spurious pulse",
                          {29'd0, row_done, buf_done, irq}, 32'd0);
                end
                pend_valid = 0;
                if (elem_ack && addr_valid) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R4 unexpected handshake", addr_out, 32'd0);
                    end else begin
                        pend = q.pop_front();
                        pend_valid = 1;
                        check(addr_out == pend.addr, "R4/R5 address", addr_out, pend.addr);
                    end
                end
            end
        end
    end

    task automatic cfg_write(logic [2:0] sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        // R13: select codes; the block is idle here so the write lands
        case (sel)
            3'd0: m_base = data;
            3'd1: m_icnt = data[15:0];
            3'd2: m_ocnt = data[15:0];
            3'd3: m_istep = data[15:0];
            3'd4: m_ostep = data[15:0];
            3'd5: begin m_circ = data[0]; m_rowirq = data[1]; end
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(logic [31:0] b, logic [15:0] ic, logic [15:0] oc,
                         logic [15:0] is, logic [15:0] os, bit circ, bit rowirq);
        cfg_write(3'd0, b);
        cfg_write(3'd1, {16'd0, ic});
        cfg_write(3'd2, {16'd0, oc});
        cfg_write(3'd3, {16'd0, is});
        cfg_write(3'd4, {16'd0, os});
        cfg_write(3'd5, {30'd0, rowirq, circ});
    endtask

    task automatic run_xfer(int n, bit gaps, bit poke);
        logic [31:0] a = m_base;
        int i = span(m_icnt);
        int o = span(m_ocnt);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.addr = a; e.row_end = (i == 1); e.buf_end = (i == 1) && (o == 1);
            e.circ = m_circ; e.rowirq = m_rowirq;
            q.push_back(e);
            if (i == 1) begin
                if (o == 1) begin
                    a = m_base; i = span(m_icnt); o = span(m_ocnt);
                end else begin
                    a = a + sext(m_ostep); i = span(m_icnt); o = o - 1;
                end
            end else begin
                a = a + sext(m_istep); i = i - 1;
            end
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        #1;
        check(addr_valid == 1'b1, "R3 running after start", 32'(addr_valid), 32'd1);
        check(addr_out == m_base, "R3 first address", addr_out, m_base);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (gaps && (k % 3 == 2)) begin
                elem_ack = 1'b0;
                @(negedge clk);
            end
            elem_ack = 1'b1;
            if (poke && k == 1) begin
                // R2: write attempted while running, must not land
                cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'hDEAD_0000;
            end else begin
                cfg_we = 1'b0;
            end
        end
        @(negedge clk);
        elem_ack = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_base = 0; m_icnt = 1; m_ocnt = 1; m_istep = 0; m_ostep = 0;
        m_circ = 0; m_rowirq = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(!addr_valid && !row_done && !buf_done && !irq, "R1 reset outputs",
              {28'd0, addr_valid, row_done, buf_done, irq}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R12: handshakes while idle
        @(negedge clk) elem_ack = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(addr_valid == 1'b0, "R12 stays idle", 32'(addr_valid), 32'd0);
        elem_ack = 1'b0;

        // R4 R5 R7 R8 R10: 4x3 with negative outer step, irq per row
        setup(32'h0000_1000, 16'd4, 16'd3, 16'd2, 16'hFFFB, 1'b0, 1'b1);
        run_xfer(12, 1'b1, 1'b0);

        // R2 R10: de-interleave shape, irq per buffer, write poked while busy
        setup(32'h0000_2000, 16'd3, 16'd2, 16'd4, 16'hFFF9, 1'b0, 1'b0);
        run_xfer(6, 1'b0, 1'b1);
        run_xfer(6, 1'b1, 1'b0);

        // R11: one-dimensional, negative inner step
        setup(32'h0000_0100, 16'd5, 16'd1, 16'hFFFF, 16'd0, 1'b0, 1'b0);
        run_xfer(5, 1'b0, 1'b0);

        // R6: zero counts mean 65536
        setup(32'h4000_0000, 16'd0, 16'd1, 16'd1, 16'd0, 1'b0, 1'b0);
        run_xfer(65536, 1'b0, 1'b0);
        setup(32'h5000_0000, 16'd1, 16'd0, 16'd0, 16'd1, 1'b0, 1'b1);
        run_xfer(65536, 1'b0, 1'b0);

        // R9 R10: circular, irq per row, crosses two wraps
        setup(32'h0000_3000, 16'd2, 16'd2, 16'd3, 16'd10, 1'b1, 1'b1);
        run_xfer(10, 1'b1, 1'b0);
        do_reset();
        #1;
        check(addr_valid == 1'b0, "R1 reset leaves circular run", 32'(addr_valid), 32'd0);

        // R9 R10: circular, irq per buffer
        setup(32'hFFFF_FFF8, 16'd3, 16'd1, 16'd4, 16'd0, 1'b1, 1'b0);
        run_xfer(9, 1'b0, 1'b0);

        check(q.size() == 0, "R4 all predictions consumed", q.size(), 32'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule